// File: doc/BRIEF.md
# Packed Lane Shift, Rotate and Halfword Shuffle Unit

This block takes a 64-bit operand and treats it, according to a lane-size code, as four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. A 32-bit count drives a left shift, a logical right shift, an arithmetic right shift or a right rotate. Each lane is handled on its own, so no bit ever moves from one lane into another. A fifth operation rearranges the four halfwords under an 8-bit selector.

Each result comes with a packed status word. For every lane it holds a negative flag, which is a copy of the lane's top bit, and a zero flag, which is set when the lane is all zeros. The positions of these flags depend on the lane size. The result and the status word are captured in one register stage. An input strobe marks the operands, and one cycle later an output strobe marks the result and status.

Top module: `psru_unit`

## Requirements
- R1: Operation code 0 shifts each lane left. Vacated bits are zero, bits pushed past the top of a lane are lost, and a count equal to or greater than the lane width clears the lane.
- R2: Operation code 1 shifts each lane right logically. Zeros enter at the top, and a count equal to or greater than the lane width clears the lane.
- R3: Operation code 2 shifts each lane right arithmetically, filling from that lane's own top bit. A count equal to or greater than the lane width fills the lane with copies of its sign bit.
- R4: Operation code 3 rotates each lane right by the count modulo the lane width. The lane's low bits reappear at its top, and a rotate by exactly the lane width leaves the lane unchanged.
- R5: Operation code 4 sets destination halfword i (bits 16i+15..16i) to source halfword number sel[2i+1:2i], for i from 0 to 3. For this operation the lane-size code has no effect, and the status word uses the 16-bit layout.
- R6: Lane-size code 0 selects 16-bit lanes. For lane k (0..3) the negative flag is at status bit 8k+7 and the zero flag is at status bit 8k+6.
- R7: Lane-size code 1 selects 32-bit lanes. For lane k (0..1) the negative flag is at bit 16k+15 and the zero flag is at bit 16k+14.
- R8: Lane-size codes 2 and 3 both select the single 64-bit lane. Its negative flag is at bit 31 and its zero flag is at bit 30.
- R9: Every status bit that is not a flag position for the active layout reads zero.
- R10: When in_valid is high at a rising edge, out_valid is high after that edge and result and flags show that operation. Otherwise out_valid is low after that edge.
- R11: An edge with in_valid low leaves result and flags unchanged.
- R12: Reset clears out_valid, result and flags.
- R13: Operation codes 5 to 7 pass the operand through unchanged. The status word follows the lane-size code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands valid this cycle |
| op | input | 3 | Operation code (0 shl, 1 shr, 2 sar, 3 ror, 4 shuffle, 5-7 pass) |
| lane_sz | input | 2 | Lane size code (0: 16, 1: 32, 2/3: 64) |
| operand | input | 64 | Packed source value |
| count | input | 32 | Shift or rotate amount |
| sel | input | 8 | Halfword shuffle selector |
| out_valid | output | 1 | Result and flags updated |
| result | output | 64 | Registered packed result |
| flags | output | 32 | Registered packed N/Z status |

## Verification
The lane datapath and the flag packer work in the same cycle. A shift can empty a lane, and that lane's zero flag must then rise in the same register update. The hard case is a count at or beyond the lane width, which clears whole lanes or fills them with sign copies. The bench drives such counts along with random counts and operands, on all lane sizes and with the shuffle. Each captured result is compared with a model result and with status bits rebuilt from that result, so a datapath that disagrees with its own flags is reported.

// File: rtl/psru_pkg.sv
package psru_pkg;
  localparam int DATA_W  = 64;
  localparam int CNT_W   = 32;
  localparam int SEL_W   = 8;
  localparam int FLAG_W  = 32;
  localparam int HALF_W  = 16;
  localparam int NHALF   = DATA_W / HALF_W;

  localparam logic [2:0] OP_SHL  = 3'd0;
  localparam logic [2:0] OP_SHR  = 3'd1;
  localparam logic [2:0] OP_SAR  = 3'd2;
  localparam logic [2:0] OP_ROR  = 3'd3;
  localparam logic [2:0] OP_SHUF = 3'd4;

  typedef enum logic [1:0] {
    LSZ_16  = 2'd0,
    LSZ_32  = 2'd1,
    LSZ_64  = 2'd2,
    LSZ_64X = 2'd3
  } lane_sz_e;

  // Pack N (lane msb) and Z (lane all zero) into the size-dependent layout.
  function automatic logic [FLAG_W-1:0] pack_flags(input logic [DATA_W-1:0] r,
                                                   input lane_sz_e sz);
    logic [FLAG_W-1:0] f;
    f = '0;
    case (sz)
      LSZ_16: begin
        for (int k = 0; k < 4; k++) begin
          f[8*k+7] = r[16*k+15];
          f[8*k+6] = (r[16*k +: 16] == 16'h0);
        end
      end
      LSZ_32: begin
        for (int k = 0; k < 2; k++) begin
          f[16*k+15] = r[32*k+31];
          f[16*k+14] = (r[32*k +: 32] == 32'h0);
        end
      end
      default: begin
        f[31] = r[63];
        f[30] = (r == '0);
      end
    endcase
    return f;
  endfunction

  // Mask of status bits that may be non-zero for a layout.
  function automatic logic [FLAG_W-1:0] flag_mask(input lane_sz_e sz);
    case (sz)
      LSZ_16:  return 32'hC0C0_C0C0;
      LSZ_32:  return 32'hC000_C000;
      default: return 32'hC000_0000;
    endcase
  endfunction
endpackage

// File: rtl/psru_lane.sv
module psru_lane #(
  parameter int LW    = 16,
  parameter int CW    = 32
) (
  input  logic [2:0]    op,
  input  logic [LW-1:0] din,
  input  logic [CW-1:0] cnt,
  output logic [LW-1:0] dout
);
  import psru_pkg::*;
  localparam int SW = $clog2(LW);

  logic              over;
  logic [SW-1:0]     amt;
  logic [2*LW-1:0]   rot_pair;
  logic signed [LW-1:0] sdin;

  assign over     = (cnt >= CW'(LW));
  assign amt      = cnt[SW-1:0];
  assign rot_pair = {din, din} >> amt;
  assign sdin     = din;

  always_comb begin
    case (op)
      OP_SHL:  dout = over ? '0 : (din << amt);
      OP_SHR:  dout = over ? '0 : (din >> amt);
      OP_SAR:  dout = over ? {LW{din[LW-1]}} : LW'(sdin >>> amt);
      OP_ROR:  dout = rot_pair[LW-1:0];
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/psru_lane_bank.sv
module psru_lane_bank #(
  parameter int DW = 64,
  parameter int LW = 16,
  parameter int CW = 32
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] cnt,
  output logic [DW-1:0] dout
);
  localparam int NL = DW / LW;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    psru_lane #(.LW(LW), .CW(CW)) u_lane (
      .op   (op),
      .din  (din[g*LW +: LW]),
      .cnt  (cnt),
      .dout (dout[g*LW +: LW])
    );
  end
endmodule

// File: rtl/psru_shuffle.sv
module psru_shuffle #(
  parameter int DW   = 64,
  parameter int HW   = 16,
  parameter int SELW = 8
) (
  input  logic [DW-1:0]   din,
  input  logic [SELW-1:0] sel,
  output logic [DW-1:0]   dout
);
  localparam int NH = DW / HW;
  localparam int IW = $clog2(NH);

  for (genvar i = 0; i < NH; i++) begin : g_half
    logic [IW-1:0] pick;
    assign pick = sel[i*IW +: IW];
    assign dout[i*HW +: HW] = din[pick*HW +: HW];
  end
endmodule

// File: rtl/psru_unit.sv
module psru_unit #(
  parameter int DW   = psru_pkg::DATA_W,
  parameter int CW   = psru_pkg::CNT_W,
  parameter int SELW = psru_pkg::SEL_W,
  parameter int FW   = psru_pkg::FLAG_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      op,
  input  logic [1:0]      lane_sz,
  input  logic [DW-1:0]   operand,
  input  logic [CW-1:0]   count,
  input  logic [SELW-1:0] sel,
  output logic            out_valid,
  output logic [DW-1:0]   result,
  output logic [FW-1:0]   flags
);
  import psru_pkg::*;

  logic [DW-1:0] res16, res32, res64, res_shuf;
  logic [DW-1:0] nxt_res;
  logic [FW-1:0] nxt_flags;
  lane_sz_e      eff_sz;
  lane_sz_e      sz_q;
  logic [2:0]    op_q;
  logic          capture;

  psru_lane_bank #(.DW(DW), .LW(16), .CW(CW)) u_bank16 (
    .op(op), .din(operand), .cnt(count), .dout(res16));
  psru_lane_bank #(.DW(DW), .LW(32), .CW(CW)) u_bank32 (
    .op(op), .din(operand), .cnt(count), .dout(res32));
  psru_lane_bank #(.DW(DW), .LW(64), .CW(CW)) u_bank64 (
    .op(op), .din(operand), .cnt(count), .dout(res64));

  psru_shuffle #(.DW(DW), .HW(HALF_W), .SELW(SELW)) u_shuf (
    .din(operand), .sel(sel), .dout(res_shuf));

  // Shuffle always reports in the halfword layout.
  assign eff_sz  = (op == OP_SHUF) ? LSZ_16 : lane_sz_e'(lane_sz);
  assign capture = in_valid;

  always_comb begin
    if (op == OP_SHUF) begin
      nxt_res = res_shuf;
    end else if (op > OP_SHUF) begin
      nxt_res = operand;
    end else begin
      case (eff_sz)
        LSZ_16:  nxt_res = res16;
        LSZ_32:  nxt_res = res32;
        default: nxt_res = res64;
      endcase
    end
  end

  assign nxt_flags = pack_flags(nxt_res, eff_sz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
      sz_q      <= LSZ_16;
      op_q      <= '0;
    end else begin
      out_valid <= capture;
      if (capture) begin
        result <= nxt_res;
        flags  <= nxt_flags;
        sz_q   <= eff_sz;
        op_q   <= op;
      end
    end
  end
endmodule

// File: rtl/psru_unit_chk.sv
module psru_unit_chk (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic [63:0]          result,
  input logic [31:0]          flags,
  input psru_pkg::lane_sz_e   sz_q,
  input logic [2:0]           op_q
);
  import psru_pkg::*;

  assert_strobe_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_strobe_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flags)));
  assert_flags16_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sz_q == LSZ_16) |->
      (flags[6] == (result[15:0] == 16'h0)) && (flags[31] == result[63]));
  assert_flags32_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sz_q == LSZ_32) |->
      (flags[14] == (result[31:0] == 32'h0)) && (flags[31] == result[63]));
  assert_flags64_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (sz_q == LSZ_64 || sz_q == LSZ_64X)) |->
      (flags[30] == (result == 64'h0)) && (flags[31] == result[63]));
  assert_spare_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(flags & ~flag_mask(sz_q)) == 0));
  assert_shuffle_layout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OP_SHUF) |-> (sz_q == LSZ_16));
endmodule

bind psru_unit psru_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .result    (result),
  .flags     (flags),
  .sz_q      (sz_q),
  .op_q      (op_q)
);

// File: tb/psru_unit_tb.sv
module psru_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  lane_sz = '0;
  logic [63:0] operand = '0;
  logic [31:0] count = '0;
  logic [7:0]  sel = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [31:0] flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  psru_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .lane_sz(lane_sz),
    .operand(operand), .count(count), .sel(sel),
    .out_valid(out_valid), .result(result), .flags(flags));

  function automatic int width_of(input logic [2:0] o, input logic [1:0] s);
    if (o == 3'd4) return 16;
    return (s == 2'd0) ? 16 : (s == 2'd1) ? 32 : 64;
  endfunction

  // Bit-by-bit model of one lane operation.
  function automatic logic [63:0] model_res(input logic [2:0] o, input logic [1:0] s,
      input logic [63:0] x, input logic [31:0] c, input logic [7:0] sl);
    logic [63:0] r;
    longint unsigned cc;
    int w;
    r = '0;
    cc = longint'(c);
    if (o == 3'd4) begin
      for (int i = 0; i < 4; i++) begin
        int src;
        src = (sl >> (2*i)) & 3;
        r[16*i +: 16] = x[16*src +: 16];
      end
      return r;
    end
    if (o > 3'd4) return x;
    w = width_of(o, s);
    for (int base = 0; base < 64; base += w) begin
      for (int b = 0; b < w; b++) begin
        longint unsigned src;
        case (o)
          3'd0: r[base+b] = (cc <= longint'(b)) ? x[base + b - int'(cc)] : 1'b0;
          3'd1: begin
            src = longint'(b) + cc;
            r[base+b] = (src < longint'(w)) ? x[base + int'(src)] : 1'b0;
          end
          3'd2: begin
            src = longint'(b) + cc;
            r[base+b] = (src < longint'(w)) ? x[base + int'(src)] : x[base + w - 1];
          end
          default: r[base+b] = x[base + int'((longint'(b) + cc) % longint'(w))];
        endcase
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] model_flags(input logic [63:0] r, input int w);
    logic [31:0] f;
    int nl, step;
    f = '0;
    nl = 64 / w;
    step = 32 / nl;
    for (int k = 0; k < nl; k++) begin
      f[step*k + step - 1] = r[w*k + w - 1];
      f[step*k + step - 2] = ((r >> (w*k)) & ((w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF
                              : ((64'd1 << w) - 1))) == 0;
    end
    return f;
  endfunction

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R13";
    endcase
  endfunction

  function automatic string flag_tag(input int w);
    return (w == 16) ? "R6 R9" : (w == 32) ? "R7 R9" : "R8 R9";
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [1:0] s,
                       input logic [63:0] x, input logic [31:0] c, input logic [7:0] sl);
    logic [63:0] er;
    int w;
    er = model_res(o, s, x, c, sl);
    w  = width_of(o, s);
    in_valid = 1'b1; op = o; lane_sz = s; operand = x; count = c; sel = sl;
    @(negedge clk);
    check64("R10 valid", {63'b0, out_valid}, 64'd1);
    check64(op_tag(o), result, er);
    check64(flag_tag(w), {32'b0, flags}, {32'b0, model_flags(er, w)});
    in_valid = 1'b0;
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] keep_r;
    logic [31:0] keep_f;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12 reset state
    check64("R12 result", result, 64'h0);
    check64("R12 flags", {32'b0, flags}, 64'h0);
    check64("R12 valid", {63'b0, out_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed corners
    apply(3'd0, 2'd0, 64'h8001_7FFF_FFFF_1234, 32'd16, 8'h00); // R1 count = width
    apply(3'd0, 2'd0, 64'h8001_7FFF_FFFF_1234, 32'd4,  8'h00); // R1 boundary bits dropped
    apply(3'd1, 2'd1, 64'hFFFF_FFFF_8000_0000, 32'd31, 8'h00); // R2
    apply(3'd1, 2'd2, 64'h0123_4567_89AB_CDEF, 32'd64, 8'h00); // R2 clears
    apply(3'd2, 2'd1, 64'h8000_0000_7FFF_FFFF, 32'd40, 8'h00); // R3 over width
    apply(3'd2, 2'd0, 64'hF000_0F00_8001_0001, 32'd3,  8'h00); // R3
    apply(3'd3, 2'd0, 64'h1234_5678_9ABC_DEF0, 32'd16, 8'h00); // R4 unchanged
    apply(3'd3, 2'd2, 64'h0000_0000_0000_000F, 32'd68, 8'h00); // R4 modulo
    apply(3'd3, 2'd1, 64'h0000_0001_8000_0001, 32'd1,  8'h00); // R4
    apply(3'd4, 2'd2, 64'h4444_3333_2222_1111, 32'd7,  8'h1B); // R5 reverse
    apply(3'd4, 2'd1, 64'h0000_8000_0000_1111, 32'd0,  8'hAA); // R5 broadcast
    apply(3'd6, 2'd1, 64'hDEAD_BEEF_0000_0000, 32'd5,  8'h00); // R13
    apply(3'd0, 2'd3, 64'h8000_0000_0000_0001, 32'd63, 8'h00); // R8 code 3

    // R11 hold: change inputs with in_valid low
    keep_r = result; keep_f = flags;
    op = 3'd1; operand = 64'hFFFF_0000_FFFF_0000; count = 32'd2; lane_sz = 2'd0;
    @(negedge clk);
    check64("R11 result", result, keep_r);
    check64("R11 flags", {32'b0, flags}, {32'b0, keep_f});
    check64("R10 idle", {63'b0, out_valid}, 64'd0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] c;
      logic [63:0] x;
      case ($urandom_range(0, 3))
        0: x = 64'h0;
        1: x = {$urandom(), $urandom()} & {4{16'hFF00}};
        default: x = {$urandom(), $urandom()};
      endcase
      c = ($urandom_range(0, 9) == 0) ? $urandom() : 32'($urandom_range(0, 70));
      apply(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), x, c, 8'($urandom()));
      if ($urandom_range(0, 4) == 0) @(negedge clk);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule